// File: doc/BRIEF.md
# Masked SIMD Lane Ring Array

This block is an array of identical 32-bit integer lanes. All lanes run in lockstep under one shared control unit. Each cycle the control unit decodes one broadcast instruction word and sends a set of strobes to every lane at once. Each lane holds:
- a 64-entry register file,
- a one-bit mask,
- a small local memory with 64-bit words.

A cleared mask bit stops a lane from writing its registers or its memory. The lane still drives its ring output, so data shifted around the ring stays consistent.

The lanes form a closed ring. A "north" shift gives every lane the selected register of the lane with the index one lower. A "south" shift takes it from the lane with the index one higher. The ring wraps at both ends.

A host uses the array in three steps:
1. While the array is halted, it fills the lane memories through a word-wide port.
2. It issues a resume instruction and streams a program.
3. It waits for the done flag raised by a halt instruction, then reads the results back.

Host reads are combinational and come from the selected lane and address.

Top module: `simd_array`

## Requirements
- R1: After reset, `done` is 0, every bit of `laneMask` is 1, and all lane registers and memory words are 0.
- R2: The instruction word fields are: op = [31:27], rd = [26:21], ra = [20:15], rb = [14:9], imm = [8:0].
  - Halt (op 11) is accepted while running and sets `done` at the next clock edge.
  - While `done` is 1, every instruction except resume (op 12) is ignored. Resume clears `done`.
- R3: A host write (`hostWe`) changes lane `hostLane`, word `hostAddr` only while `done` is 1. A host write while running is ignored. `hostRdata` shows that word of that lane combinationally.
- R4: The following operations run in every unmasked lane, with 32-bit wraparound:
  - add (op 1): rd = ra + rb
  - sub (op 2): rd = ra - rb
  - load-immediate (op 3): rd = imm sign-extended from 9 bits
- R5: The memory address is imm[MEM_AW-1:0].
  - Load (op 6) writes the word's bits [31:0] to the even register rd with bit 0 cleared, and bits [63:32] to the odd register next to it.
  - Store (op 7) writes {odd reg, even reg} of the pair selected by ra.
- R6: North shift (op 4) sets rd of lane i to ra of lane (i-1) mod LANES. South shift (op 5) takes it from lane (i+1) mod LANES. Every lane moves in the same cycle.
- R7: A lane with mask 0 changes neither its registers nor its memory for ops 1 to 7.
- R8: A lane with mask 0 still supplies its ra value to its ring neighbours.
- R9: The mask operations are:
  - compare (op 8) sets every lane's mask, whatever its current value, to signed(ra) < signed(rb);
  - mask-set (op 9) sets all masks to 1;
  - mask-invert (op 10) inverts every mask.
  - Op 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Broadcast instruction present this cycle |
| instWord | input | 32 | Broadcast instruction |
| hostLane | input | $clog2(LANES) | Lane selected by the host port |
| hostWe | input | 1 | Host memory write strobe |
| hostAddr | input | MEM_AW | Host memory word address |
| hostWdata | input | 64 | Host write data |
| hostRdata | output | 64 | Selected lane memory word |
| laneMask | output | LANES | Current mask bit of each lane |
| done | output | 1 | Array halted |

## Verification
The bench goes after the ring seams, lane 0 and lane LANES-1. A design that misses the wrap would put stale or zero data into those lanes after a shift.

It masks lanes with a signed compare, using operands whose signs differ. A design that compares unsigned would mask the wrong lanes. The bench then checks both registers and memory in the masked lanes. A design that gated only one of the two would show changed words there.

A rotate-and-accumulate run under a partial mask verifies that masked lanes keep forwarding. A design that blanks their ring output would corrupt the sums in the unmasked neighbours.

Instructions and host writes issued in the wrong run state must leave memory untouched. A design that does not gate them would show corrupted words.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int REG_AW = 6;
  localparam int NREGS  = 1 << REG_AW;
  localparam int IMM_W  = 9;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_LDI   = 5'd3,
    OP_SHN   = 5'd4,
    OP_SHS   = 5'd5,
    OP_LD    = 5'd6,
    OP_ST    = 5'd7,
    OP_CMPLT = 5'd8,
    OP_MSET  = 5'd9,
    OP_MINV  = 5'd10,
    OP_HALT  = 5'd11,
    OP_GO    = 5'd12
  } opcode_e;

  typedef enum logic [2:0] {
    SRC_ADD, SRC_SUB, SRC_IMM, SRC_NORTH, SRC_SOUTH
  } wsrc_e;

  typedef struct packed {
    logic              regWe;
    logic              pairWe;
    logic              memWe;
    logic              maskCmp;
    logic              maskSet;
    logic              maskInv;
    wsrc_e             wSrc;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [IMM_W-1:0]  imm;
  } laneCtl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output laneCtl_t    ctl,
  output logic        done
);
  opcode_e op;
  logic    accept;

  assign op     = opcode_e'(instWord[31:27]);
  assign accept = instValid && !done;

  always_comb begin
    ctl     = '0;
    ctl.rd  = instWord[26:21];
    ctl.ra  = instWord[20:15];
    ctl.rb  = instWord[14:9];
    ctl.imm = instWord[8:0];
    if (accept) begin
      case (op)
        OP_ADD:   begin ctl.regWe = 1'b1; ctl.wSrc = SRC_ADD;   end
        OP_SUB:   begin ctl.regWe = 1'b1; ctl.wSrc = SRC_SUB;   end
        OP_LDI:   begin ctl.regWe = 1'b1; ctl.wSrc = SRC_IMM;   end
        OP_SHN:   begin ctl.regWe = 1'b1; ctl.wSrc = SRC_NORTH; end
        OP_SHS:   begin ctl.regWe = 1'b1; ctl.wSrc = SRC_SOUTH; end
        OP_LD:    ctl.pairWe  = 1'b1;
        OP_ST:    ctl.memWe   = 1'b1;
        OP_CMPLT: ctl.maskCmp = 1'b1;
        OP_MSET:  ctl.maskSet = 1'b1;
        OP_MINV:  ctl.maskInv = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else if (instValid) begin
      if (done && op == OP_GO) done <= 1'b0;
      else if (!done && op == OP_HALT) done <= 1'b1;
    end
  end

  AST_HALT_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !done && instWord[31:27] == 5'd11) |=> done); // R2
  AST_GO_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && done && instWord[31:27] == 5'd12) |=> !done); // R2
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(ctl.regWe || ctl.pairWe || ctl.memWe || ctl.maskCmp || ctl.maskSet || ctl.maskInv)); // R2
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int MEM_AW = 4,
  localparam int MEM_D = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [31:0]       northIn,
  input  logic [31:0]       southIn,
  output logic [31:0]       ringOut,
  output logic              maskOut,
  input  logic              hostWe,
  input  logic [MEM_AW-1:0] hostAddr,
  input  logic [63:0]       hostWdata,
  output logic [63:0]       hostRdata
);
  logic [31:0]       rfQ [NREGS];
  logic [63:0]       memQ [MEM_D];
  logic              maskQ;
  logic [31:0]       opA, opB, wData;
  logic [MEM_AW-1:0] memAddr;
  logic [63:0]       memWord;
  logic [REG_AW-1:0] pairLo, pairHi, stLo, stHi;

  assign opA       = rfQ[ctl.ra];
  assign opB       = rfQ[ctl.rb];
  assign ringOut   = opA;
  assign maskOut   = maskQ;
  assign memAddr   = ctl.imm[MEM_AW-1:0];
  assign memWord   = memQ[memAddr];
  assign hostRdata = memQ[hostAddr];
  assign pairLo    = {ctl.rd[REG_AW-1:1], 1'b0};
  assign pairHi    = {ctl.rd[REG_AW-1:1], 1'b1};
  assign stLo      = {ctl.ra[REG_AW-1:1], 1'b0};
  assign stHi      = {ctl.ra[REG_AW-1:1], 1'b1};

  always_comb begin
    case (ctl.wSrc)
      SRC_ADD:   wData = opA + opB;
      SRC_SUB:   wData = opA - opB;
      SRC_IMM:   wData = {{(32-IMM_W){ctl.imm[IMM_W-1]}}, ctl.imm};
      SRC_NORTH: wData = northIn;
      SRC_SOUTH: wData = southIn;
      default:   wData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++) rfQ[r] <= '0;
    end else if (maskQ) begin
      if (ctl.regWe) rfQ[ctl.rd] <= wData;
      if (ctl.pairWe) begin
        rfQ[pairLo] <= memWord[31:0];
        rfQ[pairHi] <= memWord[63:32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < MEM_D; w++) memQ[w] <= '0;
    end else if (ctl.memWe && maskQ) memQ[memAddr] <= {rfQ[stHi], rfQ[stLo]};
    else if (hostWe) memQ[hostAddr] <= hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= 1'b1;
    else if (ctl.maskCmp) maskQ <= $signed(opA) < $signed(opB);
    else if (ctl.maskSet) maskQ <= 1'b1;
    else if (ctl.maskInv) maskQ <= ~maskQ;
  end

  logic [31:0] oldReg;
  logic [63:0] oldMem;
  assign oldReg = rfQ[ctl.rd];
  assign oldMem = memQ[memAddr];

  AST_MASKED_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWe && !maskQ) |=> rfQ[$past(ctl.rd)] == $past(oldReg)); // R7
  AST_MASKED_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWe && !maskQ) |=> memQ[$past(memAddr)] == $past(oldMem)); // R7
  AST_LOAD_PAIR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pairWe && maskQ) |=> rfQ[$past(pairLo)] == $past(memWord[31:0])); // R5
  AST_MASK_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.maskInv |=> maskQ != $past(maskQ)); // R9
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int MEM_AW = 4,
  localparam int LW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [LW-1:0]     hostLane,
  input  logic              hostWe,
  input  logic [MEM_AW-1:0] hostAddr,
  input  logic [63:0]       hostWdata,
  output logic [63:0]       hostRdata,
  output logic [LANES-1:0]  laneMask,
  output logic              done
);
  laneCtl_t    ctl;
  logic [31:0] ringOut [LANES];
  logic [63:0] laneRd  [LANES];

  simd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .ctl(ctl), .done(done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int NORTH = (i + LANES - 1) % LANES;
    localparam int SOUTH = (i + 1) % LANES;
    logic laneHostWe;
    assign laneHostWe = hostWe && done && (hostLane == LW'(i));
    simd_lane #(.MEM_AW(MEM_AW)) u_lane (
      .clk(clk), .rstN(rstN), .ctl(ctl),
      .northIn(ringOut[NORTH]), .southIn(ringOut[SOUTH]),
      .ringOut(ringOut[i]), .maskOut(laneMask[i]),
      .hostWe(laneHostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
      .hostRdata(laneRd[i])
    );
  end

  assign hostRdata = laneRd[hostLane];

  AST_MSET_ALL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.maskSet |=> (&laneMask)); // R9
endmodule

// File: tb/tb_simd_array.sv
module tb_simd_array;
  localparam int LANES = 32;
  localparam int MEM_AW = 4;
  localparam int MEM_D = 1 << MEM_AW;
  localparam int LW = $clog2(LANES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [LW-1:0] hostLane = '0;
  logic hostWe = 1'b0;
  logic [MEM_AW-1:0] hostAddr = '0;
  logic [63:0] hostWdata = '0;
  logic [63:0] hostRdata;
  logic [LANES-1:0] laneMask;
  logic done;

  simd_array #(.LANES(LANES), .MEM_AW(MEM_AW)) dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .hostLane(hostLane), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .laneMask(laneMask), .done(done)
  );

  always #4 clk = ~clk;

  int nRun = 0, nFail = 0;
  logic [31:0] mReg [LANES][64];
  logic [63:0] mMem [LANES][MEM_D];
  logic        mMask [LANES];
  logic        mDone;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [4:0] op, input int rd, input int ra, input int rb, input logic [8:0] imm);
    logic [31:0] oldRa [LANES];
    logic [63:0] w;
    int a;
    a = imm % MEM_D;
    for (int l = 0; l < LANES; l++) oldRa[l] = mReg[l][ra];
    if (mDone) begin
      if (op == 5'd12) mDone = 1'b0;
      return;
    end
    if (op == 5'd11) mDone = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      case (op)
        5'd1: if (mMask[l]) mReg[l][rd] = mReg[l][ra] + mReg[l][rb];
        5'd2: if (mMask[l]) mReg[l][rd] = mReg[l][ra] - mReg[l][rb];
        5'd3: if (mMask[l]) mReg[l][rd] = {{23{imm[8]}}, imm};
        5'd4: if (mMask[l]) mReg[l][rd] = oldRa[(l + LANES - 1) % LANES];
        5'd5: if (mMask[l]) mReg[l][rd] = oldRa[(l + 1) % LANES];
        5'd6: if (mMask[l]) begin
          w = mMem[l][a];
          mReg[l][rd & ~1] = w[31:0];
          mReg[l][rd | 1]  = w[63:32];
        end
        5'd7: if (mMask[l]) mMem[l][a] = {mReg[l][ra | 1], mReg[l][ra & ~1]};
        5'd8: mMask[l] = $signed(mReg[l][ra]) < $signed(mReg[l][rb]);
        5'd9: mMask[l] = 1'b1;
        5'd10: mMask[l] = ~mMask[l];
        default: ;
      endcase
    end
  endtask

  task automatic issue(input logic [4:0] op, input int rd, input int ra, input int rb, input logic [8:0] imm);
    @(negedge clk);
    instValid = 1'b1;
    instWord = {op, 6'(rd), 6'(ra), 6'(rb), imm};
    model(op, rd, ra, rb, imm);
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic hostWrite(input int lane, input int addr, input logic [63:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostLane = LW'(lane); hostAddr = MEM_AW'(addr); hostWdata = d;
    if (mDone) mMem[lane][addr] = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input int lane, input int addr, output logic [63:0] d);
    hostLane = LW'(lane); hostAddr = MEM_AW'(addr);
    #1 d = hostRdata;
  endtask

  task automatic checkMem(input string req, input int addr);
    logic [63:0] d;
    for (int l = 0; l < LANES; l++) begin
      hostRead(l, addr, d);
      chk(req, d, mMem[l][addr]);
    end
  endtask

  task automatic checkMask(input string req);
    logic [LANES-1:0] e;
    for (int l = 0; l < LANES; l++) e[l] = mMask[l];
    chk(req, 64'(laneMask), 64'(e));
  endtask

  task automatic t_reset();
    chk("R1 done", 64'(done), 64'd0);
    checkMask("R1 mask");
    checkMem("R1 mem", 2);
  endtask

  task automatic t_haltLoad();
    issue(5'd11, 0, 0, 0, 9'd0); idle();
    chk("R2 halt done", 64'(done), 64'd1);
    for (int l = 0; l < LANES; l++)
      for (int w = 0; w < MEM_D; w++)
        hostWrite(l, w, {$urandom, $urandom});
    hostWrite(0, 0, {32'h1, 32'h7FFF_FFFF});
    hostWrite(LANES - 1, 0, {32'h8000_0000, 32'hFFFF_FFFF});
    checkMem("R3 host load", 0);
    issue(5'd12, 0, 0, 0, 9'd0); idle();
    chk("R2 go clears", 64'(done), 64'd0);
    hostWrite(3, 1, 64'hDEAD_BEEF_0BAD_F00D);
  endtask

  task automatic t_arith();
    issue(5'd6, 0, 0, 0, 9'd0);
    issue(5'd1, 2, 0, 1, 9'd0);
    issue(5'd2, 3, 0, 1, 9'd0);
    issue(5'd7, 0, 2, 0, 9'd2);
    issue(5'd3, 4, 0, 0, 9'h1FB);
    issue(5'd3, 5, 0, 0, 9'd7);
    issue(5'd7, 0, 4, 0, 9'd3);
    issue(5'd11, 0, 0, 0, 9'd0); idle();
    checkMem("R4 R5 add sub", 2);
    checkMem("R4 immediate", 3);
    checkMem("R3 running write ignored", 1);
  endtask

  task automatic t_ring();
    issue(5'd12, 0, 0, 0, 9'd0);
    issue(5'd4, 6, 0, 0, 9'd0);
    issue(5'd5, 7, 0, 0, 9'd0);
    issue(5'd7, 0, 6, 0, 9'd4);
    issue(5'd11, 0, 0, 0, 9'd0); idle();
    checkMem("R6 ring shift wrap", 4);
  endtask

  task automatic t_ignored();
    issue(5'd3, 4, 0, 0, 9'd1);
    issue(5'd7, 0, 4, 0, 9'd3);
    issue(5'd10, 0, 0, 0, 9'd0); idle();
    chk("R2 still halted", 64'(done), 64'd1);
    checkMask("R2 mask untouched");
    checkMem("R2 halted store ignored", 3);
  endtask

  task automatic t_mask();
    issue(5'd12, 0, 0, 0, 9'd0);
    issue(5'd8, 0, 0, 1, 9'd0); idle();
    checkMask("R9 signed compare");
    issue(5'd10, 0, 0, 0, 9'd0); idle();
    checkMask("R9 invert");
    issue(5'd10, 0, 0, 0, 9'd0);
    issue(5'd3, 8, 0, 0, 9'd100);
    issue(5'd4, 9, 0, 0, 9'd0);
    issue(5'd7, 0, 8, 0, 9'd5);
    issue(5'd9, 0, 0, 0, 9'd0); idle();
    checkMask("R9 set all");
    issue(5'd7, 0, 8, 0, 9'd6);
    issue(5'd11, 0, 0, 0, 9'd0); idle();
    checkMem("R7 masked store held", 5);
    checkMem("R7 R8 masked regs and forwarding", 6);
  endtask

  task automatic t_rotAcc();
    issue(5'd12, 0, 0, 0, 9'd0);
    issue(5'd9, 0, 0, 0, 9'd0);
    issue(5'd3, 10, 0, 0, 9'd0);
    issue(5'd3, 11, 0, 0, 9'd0);
    issue(5'd1, 12, 0, 11, 9'd0);
    issue(5'd8, 0, 0, 1, 9'd0);
    for (int k = 0; k < LANES; k++) begin
      issue(5'd4, 12, 12, 0, 9'd0);
      issue(5'd1, 10, 10, 12, 9'd0);
    end
    issue(5'd9, 0, 0, 0, 9'd0);
    issue(5'd7, 0, 10, 0, 9'd7);
    issue(5'd7, 0, 12, 0, 9'd8);
    issue(5'd11, 0, 0, 0, 9'd0); idle();
    checkMem("R8 rotate accumulate", 7);
    checkMem("R6 R7 rotated value", 8);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin
      mMask[l] = 1'b1;
      for (int r = 0; r < 64; r++) mReg[l][r] = '0;
      for (int w = 0; w < MEM_D; w++) mMem[l][w] = '0;
    end
    mDone = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_haltLoad();
    t_arith();
    t_ring();
    t_ignored();
    t_mask();
    t_rotAcc();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule